// File: doc/BRIEF.md
# Eight-Channel Ultrasonic Ranging Sequencer

This block runs eight ultrasonic range sensors in turn, one per time slot. Every sensor has its own active-low trigger output and its own echo input, which is inverted inside the block. Each channel has its own counter. The counter adds one for every clock in which the inverted echo is high, so the count measures the echo pulse width in clocks.

At the end of a slot the block takes the count of the selected channel and divides it by a fixed clocks-per-millimetre constant. A quotient above the range limit is stored as zero, and the result goes into that channel's distance register. The block then clears the channel's counter, drives its trigger low for the trigger width and re-arms the counter. Finally it steps the channel index by three, modulo eight, so that neighbouring sensors never fire one after the other. Software reads the stored distances through a plain indexed read port.

Each stored result also appears on an update stream for one clock: `upd_valid` with the channel and the distance. The stream has no ready input and cannot be stalled. A consumer that wants every result must take it in the cycle it is offered. Otherwise it can poll the read port, which always holds the latest value. The slot length, trigger width and divisor default to values derived from the clock frequency, speed of sound, slot time and trigger time. Each can be overridden.

Top module: `sonar_ranger`

## Requirements
- R1: After reset every stored distance reads 0, every `trig_n` bit is 1, and the first channel served is channel 0.
- R2: Exactly one update is produced per slot, successive updates are `SLOT_CYC` clocks apart, and the channels are served in the order 0,3,6,1,4,7,2,5, repeating.
- R3: In each slot only the served channel's `trig_n` goes low, for exactly `TRIG_CYC` consecutive clocks, after that channel's update; no two trigger lines are ever low together.
- R4: A channel's counter adds one per clock edge at which its `echo_n` bit is 0 while the channel is armed. Arming starts at the edge where its trigger returns high and lasts until the channel's next read. Echo activity while its trigger is low is not counted.
- R5: The stored distance is the counter value divided by `MM_DIV`, rounded down.
- R6: A quotient greater than `MAX_MM` is stored as 0; a quotient equal to `MAX_MM` is stored unchanged.
- R7: A counter stops at its all-ones value instead of wrapping, so an echo that stays active beyond the counter range yields a stored 0 whenever all-ones divided by `MM_DIV` exceeds `MAX_MM`.
- R8: `upd_valid` is high for one clock per slot with `upd_chan` and `upd_mm` describing the stored value. That value is visible on the read port in the same cycle, and it never exceeds `MAX_MM`.
- R9: `rd_mm` shows the stored distance of the channel selected by `rd_idx` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| echo_n | input | N_CH | Echo lines, active low; bit i belongs to channel i |
| trig_n | output | N_CH | Trigger lines, active low; bit i belongs to channel i |
| rd_idx | input | IDX_W | Channel selected on the read port |
| rd_mm | output | DIST_W | Stored distance of the selected channel, millimetres |
| upd_valid | output | 1 | One-clock strobe marking a new stored result |
| upd_chan | output | IDX_W | Channel of the new result |
| upd_mm | output | DIST_W | Value of the new result, millimetres |

## Verification
The checker watches four things on every cycle:
- no two trigger lines are ever low together;
- every trigger pulse lasts exactly the configured width;
- updates follow the step-by-three channel order;
- an update never exceeds the range limit and shows up at once on the read port whenever that channel is selected.

Only the bench scenarios can show the arithmetic of the distance path. These include exact counting of echo clocks from the moment of re-arming, the discarding of echo activity while the trigger is low, floor division, the behaviour at the clamp boundary and counter saturation. In those scenarios, pulses of chosen lengths are driven after each trigger, and each later update is compared with a value computed from the pulse length.

// File: rtl/sonar_ranger_pkg.sv
package sonar_ranger_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_DIVIDE = 2'd1,
    SEQ_FIRE   = 2'd2
  } seq_state_e;

endpackage

// File: rtl/sonar_echo_bank.sv
// Per-channel echo width counters with saturation and arm/clear control.
module sonar_echo_bank #(
  parameter int N_CH  = 8,
  parameter int CNT_W = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [N_CH-1:0]             echo_n,
  input  logic [N_CH-1:0]             clr_mask,
  input  logic [N_CH-1:0]             arm_mask,
  output logic [N_CH-1:0][CNT_W-1:0]  cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        armed_q <= 1'b1;
        cnt_q   <= '0;
      end else if (clr_mask[g]) begin
        // Cleared and held idle until the trigger pulse ends (R4)
        armed_q <= 1'b0;
        cnt_q   <= '0;
      end else begin
        if (arm_mask[g]) armed_q <= 1'b1;
        if (armed_q && !echo_n[g] && (cnt_q != CNT_MAX))
          cnt_q <= cnt_q + 1'b1;   // saturates at all ones (R7)
      end
    end

    assign cnt[g] = cnt_q;
  end

endmodule

// File: rtl/sonar_div.sv
// Restoring divider by a constant, one quotient bit per clock.
module sonar_div #(
  parameter int DVD_W   = 32,
  parameter int DIVISOR = 1676
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [DVD_W-1:0] dividend,
  output logic             done,
  output logic [DVD_W-1:0] quotient
);

  localparam int DSR_W = $clog2(DIVISOR + 1);
  localparam int ITR_W = $clog2(DVD_W + 1);
  localparam logic [DSR_W:0] DSR_EXT = (DSR_W + 1)'(DIVISOR);

  logic             busy_q;
  logic             done_q;
  logic [ITR_W-1:0] iter_q;
  logic [DSR_W-1:0] rem_q;
  logic [DVD_W-1:0] quo_q;

  logic [DSR_W:0]   trial;
  logic [DSR_W:0]   diff;
  logic             fits;

  always_comb begin
    trial = {rem_q, quo_q[DVD_W-1]};
    fits  = (trial >= DSR_EXT);
    diff  = trial - DSR_EXT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      iter_q <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        busy_q <= 1'b1;
        iter_q <= '0;
        rem_q  <= '0;
        quo_q  <= dividend;
      end else if (busy_q) begin
        rem_q <= fits ? diff[DSR_W-1:0] : trial[DSR_W-1:0];
        quo_q <= {quo_q[DVD_W-2:0], fits};
        if (iter_q == ITR_W'(DVD_W - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          iter_q <= iter_q + 1'b1;
        end
      end
    end
  end

  assign done     = done_q;
  assign quotient = quo_q;

endmodule

// File: rtl/sonar_slot_seq.sv
// Slot timer, channel stepping and trigger pulse generation.
module sonar_slot_seq
  import sonar_ranger_pkg::*;
#(
  parameter int N_CH     = 8,
  parameter int STEP     = 3,
  parameter int SLOT_CYC = 1000,
  parameter int TRIG_CYC = 10,
  parameter int IDX_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_done,
  output logic             div_start,
  output logic             store_en,
  output logic [IDX_W-1:0] idx,
  output logic [N_CH-1:0]  clr_mask,
  output logic [N_CH-1:0]  arm_mask,
  output logic [N_CH-1:0]  trig_n
);

  localparam int TMR_W = $clog2(SLOT_CYC);
  localparam int TRG_W = $clog2(TRIG_CYC + 1);

  seq_state_e       state_q;
  logic [TMR_W-1:0] tmr_q;
  logic [TRG_W-1:0] trg_q;
  logic [IDX_W-1:0] idx_q;
  logic             tick;
  logic             fire_last;

  assign tick      = (tmr_q == TMR_W'(SLOT_CYC - 1));
  assign fire_last = (state_q == SEQ_FIRE) && (trg_q == TRG_W'(TRIG_CYC - 1));
  assign div_start = (state_q == SEQ_IDLE) && tick;
  assign store_en  = (state_q == SEQ_DIVIDE) && div_done;
  assign idx       = idx_q;

  // Free-running slot timer keeps the slot period independent of the FSM (R2)
  always_ff @(posedge clk) begin
    if (!rst_n)    tmr_q <= '0;
    else if (tick) tmr_q <= '0;
    else           tmr_q <= tmr_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      trg_q   <= '0;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE:   if (tick) state_q <= SEQ_DIVIDE;
        SEQ_DIVIDE: if (div_done) begin
                      state_q <= SEQ_FIRE;
                      trg_q   <= '0;
                    end
        SEQ_FIRE:   if (fire_last) begin
                      state_q <= SEQ_IDLE;
                      idx_q   <= IDX_W'((int'(idx_q) + STEP) % N_CH);  // R2 order
                    end else begin
                      trg_q <= trg_q + 1'b1;
                    end
        default:    state_q <= SEQ_IDLE;
      endcase
    end
  end

  for (genvar g = 0; g < N_CH; g++) begin : g_line
    logic sel;
    assign sel         = (idx_q == IDX_W'(g));
    assign clr_mask[g] = store_en && sel;
    assign arm_mask[g] = fire_last && sel;
    assign trig_n[g]   = !((state_q == SEQ_FIRE) && sel);   // R3
  end

endmodule

// File: rtl/sonar_ranger.sv
// Eight-channel ultrasonic ranging sequencer, top level.
module sonar_ranger #(
  parameter int N_CH         = 8,
  parameter int STEP         = 3,
  parameter int CLK_HZ       = 285_000_000,
  parameter int SLOT_MS      = 50,
  parameter int TRIG_US      = 40,
  parameter int SOUND_MM_S   = 340_000,
  parameter int SLOT_CYC     = (CLK_HZ / 1000) * SLOT_MS,
  parameter int TRIG_CYC     = (CLK_HZ / 1_000_000) * TRIG_US,
  parameter int MM_DIV       = (2 * CLK_HZ) / SOUND_MM_S,
  parameter int CNT_W        = 32,
  parameter int MAX_MM       = 9999,
  localparam int IDX_W       = $clog2(N_CH),
  localparam int DIST_W      = $clog2(MAX_MM + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_CH-1:0]   echo_n,
  output logic [N_CH-1:0]   trig_n,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DIST_W-1:0] rd_mm,
  output logic              upd_valid,
  output logic [IDX_W-1:0]  upd_chan,
  output logic [DIST_W-1:0] upd_mm
);

  logic [N_CH-1:0][CNT_W-1:0] cnt;
  logic [N_CH-1:0]            clr_mask;
  logic [N_CH-1:0]            arm_mask;
  logic [IDX_W-1:0]           idx;
  logic                       div_start;
  logic                       div_done;
  logic                       store_en;
  logic [CNT_W-1:0]           quo;
  logic [DIST_W-1:0]          clamped;

  logic [N_CH-1:0][DIST_W-1:0] dist_q;
  logic                        upd_valid_q;
  logic [IDX_W-1:0]            upd_chan_q;
  logic [DIST_W-1:0]           upd_mm_q;

  sonar_slot_seq #(
    .N_CH     (N_CH),
    .STEP     (STEP),
    .SLOT_CYC (SLOT_CYC),
    .TRIG_CYC (TRIG_CYC),
    .IDX_W    (IDX_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_done  (div_done),
    .div_start (div_start),
    .store_en  (store_en),
    .idx       (idx),
    .clr_mask  (clr_mask),
    .arm_mask  (arm_mask),
    .trig_n    (trig_n)
  );

  sonar_echo_bank #(
    .N_CH  (N_CH),
    .CNT_W (CNT_W)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .echo_n   (echo_n),
    .clr_mask (clr_mask),
    .arm_mask (arm_mask),
    .cnt      (cnt)
  );

  sonar_div #(
    .DVD_W   (CNT_W),
    .DIVISOR (MM_DIV)
  ) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .dividend (cnt[idx]),
    .done     (div_done),
    .quotient (quo)
  );

  // Out-of-range results become zero (R6)
  assign clamped = (quo > CNT_W'(MAX_MM)) ? '0 : DIST_W'(quo);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dist_q      <= '0;
      upd_valid_q <= 1'b0;
      upd_chan_q  <= '0;
      upd_mm_q    <= '0;
    end else begin
      upd_valid_q <= store_en;
      if (store_en) begin
        dist_q[idx] <= clamped;
        upd_chan_q  <= idx;
        upd_mm_q    <= clamped;
      end
    end
  end

  assign rd_mm     = dist_q[rd_idx];   // R9
  assign upd_valid = upd_valid_q;
  assign upd_chan  = upd_chan_q;
  assign upd_mm    = upd_mm_q;

endmodule

// File: rtl/sonar_ranger_chk.sv
// Cycle-by-cycle properties of the ranging sequencer.
module sonar_ranger_chk #(
  parameter int N_CH     = 8,
  parameter int STEP     = 3,
  parameter int TRIG_CYC = 10,
  parameter int MAX_MM   = 9999,
  parameter int IDX_W    = 3,
  parameter int DIST_W   = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_CH-1:0]   trig_n,
  input logic [IDX_W-1:0]  rd_idx,
  input logic [DIST_W-1:0] rd_mm,
  input logic              upd_valid,
  input logic [IDX_W-1:0]  upd_chan,
  input logic [DIST_W-1:0] upd_mm
);

  logic             in_trig;
  logic             in_trig_q;
  int unsigned      low_run_q;
  logic [IDX_W-1:0] exp_chan_q;

  assign in_trig = !(&trig_n);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_trig_q  <= 1'b0;
      low_run_q  <= 0;
      exp_chan_q <= '0;
    end else begin
      in_trig_q <= in_trig;
      low_run_q <= in_trig ? low_run_q + 1 : 0;
      if (upd_valid) exp_chan_q <= IDX_W'((int'(exp_chan_q) + STEP) % N_CH);
    end
  end

  p_single_trigger_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~trig_n));

  p_trigger_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_trig_q && !in_trig) |-> (low_run_q == TRIG_CYC));

  p_channel_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> (upd_chan == exp_chan_q));

  p_result_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> (upd_mm <= DIST_W'(MAX_MM)));

  p_result_readable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && (rd_idx == upd_chan)) |-> (rd_mm == upd_mm));

endmodule

bind sonar_ranger sonar_ranger_chk #(
  .N_CH     (N_CH),
  .STEP     (STEP),
  .TRIG_CYC (TRIG_CYC),
  .MAX_MM   (MAX_MM),
  .IDX_W    (IDX_W),
  .DIST_W   (DIST_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .trig_n    (trig_n),
  .rd_idx    (rd_idx),
  .rd_mm     (rd_mm),
  .upd_valid (upd_valid),
  .upd_chan  (upd_chan),
  .upd_mm    (upd_mm)
);

// File: tb/sonar_ranger_bench.sv
module sonar_ranger_bench;

  localparam int N_CH     = 8;
  localparam int STEP     = 3;
  localparam int SLOT_CYC = 200;
  localparam int TRIG_CYC = 5;
  localparam int MM_DIV   = 7;
  localparam int CNT_W    = 10;
  localparam int MAX_MM   = 100;
  localparam int IDX_W    = 3;
  localparam int DIST_W   = 7;
  localparam int CNT_MAX  = (1 << CNT_W) - 1;
  localparam int N_UPD    = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [N_CH-1:0]   echo_n = '1;
  logic [N_CH-1:0]   trig_n;
  logic [IDX_W-1:0]  rd_idx = '0;
  logic [DIST_W-1:0] rd_mm;
  logic              upd_valid;
  logic [IDX_W-1:0]  upd_chan;
  logic [DIST_W-1:0] upd_mm;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  int exp_cnt  [N_CH];
  int rem_len  [N_CH];
  int low_len  [N_CH];
  int arm_round[N_CH];
  logic [N_CH-1:0] prev_trig;

  always #10 clk = ~clk;   // 50 MHz

  sonar_ranger #(
    .N_CH     (N_CH),
    .STEP     (STEP),
    .SLOT_CYC (SLOT_CYC),
    .TRIG_CYC (TRIG_CYC),
    .MM_DIV   (MM_DIV),
    .CNT_W    (CNT_W),
    .MAX_MM   (MAX_MM)
  ) u_sonar_ranger (
    .clk       (clk),
    .rst_n     (rst_n),
    .echo_n    (echo_n),
    .trig_n    (trig_n),
    .rd_idx    (rd_idx),
    .rd_mm     (rd_mm),
    .upd_valid (upd_valid),
    .upd_chan  (upd_chan),
    .upd_mm    (upd_mm)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int pulse_len(input int k);
    case (k % 16)
      0:  return 0;
      1:  return 1;
      2:  return 6;
      3:  return 7;
      4:  return 8;
      5:  return 13;
      6:  return 14;
      7:  return 699;
      8:  return 700;
      9:  return 701;
      10: return 706;
      11: return 707;
      12: return 708;
      13: return 1022;
      14: return 1023;
      default: return 1300;
    endcase
  endfunction

  function automatic int expect_mm(input int cnt);
    int q;
    q = cnt / MM_DIV;
    return (q > MAX_MM) ? 0 : q;
  endfunction

  function automatic string tag_for(input int ch, input int cnt);
    if (cnt >= CNT_MAX) return "R7";
    if (cnt / MM_DIV > MAX_MM) return "R6";
    if (cnt / MM_DIV == MAX_MM) return "R6";
    if (ch == 2) return "R4";
    return "R5";
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d expected %0d updates", 0, N_UPD);
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : stimulus
    int nupd;
    int exp_chan;
    int last_upd_cyc;
    int cyc;
    int exp_v;
    for (int c = 0; c < N_CH; c++) begin
      exp_cnt[c] = 0; rem_len[c] = 0; low_len[c] = 0; arm_round[c] = 0;
    end
    nupd = 0; exp_chan = 0; last_upd_cyc = -1; cyc = 0;

    // R1 / R9: reset state through the read port
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(trig_n == '1, "R1 triggers idle", int'(trig_n), 255);
    for (int c = 0; c < N_CH; c++) begin
      rd_idx = IDX_W'(c);
      #1;
      check(rd_mm == 0, "R1 R9 reset distance", int'(rd_mm), 0);
    end
    prev_trig = trig_n;

    while (nupd < N_UPD) begin
      @(negedge clk);
      cyc++;

      // trigger monitoring and echo pulse scheduling
      if (!(&trig_n))
        check($countones(~trig_n) == 1, "R3 single trigger", $countones(~trig_n), 1);
      for (int c = 0; c < N_CH; c++) begin
        if (!trig_n[c]) low_len[c]++;
        if (trig_n[c] && !prev_trig[c]) begin
          int len;
          check(low_len[c] == TRIG_CYC, "R3 trigger width", low_len[c], TRIG_CYC);
          len = pulse_len(arm_round[c] * 8 + c);
          rem_len[c] = len;
          exp_cnt[c] = (len > CNT_MAX) ? CNT_MAX : len;
          arm_round[c]++;
        end
        if (trig_n[c]) low_len[c] = 0;
        if (rem_len[c] > 0) begin
          echo_n[c] = 1'b0;
          rem_len[c]--;
        end else if (c == 2 && !trig_n[c]) begin
          echo_n[c] = 1'b0;   // activity during trigger must be ignored (R4)
        end else begin
          echo_n[c] = 1'b1;
        end
      end
      prev_trig = trig_n;

      if (upd_valid) begin
        check(int'(upd_chan) == exp_chan, "R2 channel order", int'(upd_chan), exp_chan);
        if (last_upd_cyc >= 0)
          check(cyc - last_upd_cyc == SLOT_CYC, "R2 slot spacing", cyc - last_upd_cyc, SLOT_CYC);
        last_upd_cyc = cyc;
        exp_v = expect_mm(exp_cnt[upd_chan]);
        check(int'(upd_mm) == exp_v, tag_for(int'(upd_chan), exp_cnt[upd_chan]),
              int'(upd_mm), exp_v);
        rd_idx = upd_chan;
        #1;
        check(int'(rd_mm) == exp_v, "R8 R9 stored value readable", int'(rd_mm), exp_v);
        exp_chan = (exp_chan + STEP) % N_CH;
        nupd++;
      end
    end

    repeat (5) @(negedge clk);
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule